// File: doc/BRIEF.md
# Masked Packed Int64-to-Double Converter

This block turns a vector of signed 64-bit integers into IEEE-754 double-precision values, one conversion per 64-bit lane. The active vector is 128, 256 or 512 bits wide, which gives 2, 4 or 8 lanes. A per-lane mask chooses which lanes receive a converted value. Each lane that is masked off either keeps the matching lane of a supplied prior destination vector (merging) or is cleared (zeroing). Every result bit above the active length is cleared.

One control bit has two meanings, and the operand form decides which one applies. In the memory form it broadcasts source element zero to every lane. In the register form at full 512-bit length it makes the embedded rounding field override the global one. If the 4-bit reserved field does not hold all ones, the operation is rejected: the invalid-encoding flag is raised and the prior destination passes through untouched. An inexact flag reports whether any active lane lost precision.

The outputs are registered and appear one cycle after the input strobe. They then hold until the next strobe.

Top module: `masked_i2d_cvt`

## Requirements
- R1: Lane j uses bits 64*j+63..64*j. The vector-length code `vlen_i` selects the lane count: 00 gives 2 lanes (128 bits), 01 gives 4 lanes (256 bits), and both 10 and 11 give 8 lanes (512 bits).
- R2: An active lane yields the correctly rounded double of its signed integer. Zero yields +0.0 (all bits 0), and -2^63 yields 0xC3E0000000000000 exactly.
- R3: A lane is active when `nomask_i`=1 or its `mask_i[j]`=1. With `zero_i`=0, an inactive lane inside the length outputs the matching lane of `dst_prev_i`.
- R4: With `zero_i`=1, an inactive lane inside the length outputs zero.
- R5: All result bits from the active length up to bit 511 are zero.
- R6: The rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R7: Unless R9 applies, the rounding mode comes from `rc_glb_i`.
- R8: With `mem_form_i`=1 and `bcst_rc_i`=1, every active lane converts `src_i[63:0]`.
- R9: With `mem_form_i`=0, `bcst_rc_i`=1 and a 512-bit length, the rounding mode comes from `rc_emb_i`.
- R10: If `rsvd_i` is not 4'b1111, `bad_enc_o`=1, `res_o` equals `dst_prev_i` in full, and `inexact_o`=0. Otherwise `bad_enc_o`=0.
- R11: `inexact_o` is the OR of "result was rounded" over active lanes inside the length only.
- R12: `valid_o`, `res_o` and the flags update on the clock edge that samples `valid_i`=1. `valid_o` is 1 exactly in the cycle after a strobe. The other outputs hold while `valid_i`=0. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| src_i | input | 512 | Source integer lanes |
| dst_prev_i | input | 512 | Prior destination for merging |
| mask_i | input | 8 | Per-lane write mask |
| nomask_i | input | 1 | Treat all lanes as active |
| zero_i | input | 1 | Zeroing (1) or merging (0) for masked lanes |
| vlen_i | input | 2 | Vector length code |
| mem_form_i | input | 1 | Memory operand form |
| bcst_rc_i | input | 1 | Broadcast / embedded-rounding bit |
| rc_emb_i | input | 2 | Embedded rounding control |
| rc_glb_i | input | 2 | Global rounding control |
| rsvd_i | input | 4 | Reserved field, must be 4'b1111 |
| valid_o | output | 1 | Result valid |
| res_o | output | 512 | Result vector |
| inexact_o | output | 1 | Precision lost in an active lane |
| bad_enc_o | output | 1 | Reserved field was not all ones |

## Verification
The assertions assume that the operation controls are stable around the sampling edge. They also assume that `dst_prev_i` and the mask controls are defined whenever `valid_i` is high, so that the past values they compare against mean something. The bench drives every input on the falling edge, pulses `valid_i` for one cycle per operation, and holds `valid_i` low during reset. The hold checks therefore see only idle cycles in which the inputs change while the strobe is low.

// File: rtl/i2d_pkg.sv
package i2d_pkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_DOWN      = 2'b01,
    RM_UP        = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;

  localparam int unsigned LANE_W  = 64;
  localparam int unsigned EXP_W   = 11;
  localparam int unsigned FRAC_W  = 52;
  localparam int unsigned MAX_LN  = 8;
endpackage

// File: rtl/i2d_lane.sv
module i2d_lane
  import i2d_pkg::*;
#(
  parameter int unsigned W    = LANE_W,
  parameter int unsigned EW   = EXP_W,
  parameter int unsigned FW   = FRAC_W
) (
  input  logic [W-1:0] int_i,
  input  rmode_e       rm_i,
  output logic [W-1:0] fp_o,
  output logic         inexact_o
);
  localparam int unsigned SIG_W = FW + 1;
  localparam int unsigned DROP  = W - SIG_W;
  localparam int unsigned BIAS  = (1 << (EW - 1)) - 1;
  localparam int unsigned LZ_W  = $clog2(W) + 1;

  logic            sgn, found, g_bit, s_bit, inc;
  logic [W-1:0]    mag, norm;
  logic [LZ_W-1:0] lz;
  logic [SIG_W:0]  sum;
  logic [EW-1:0]   ex;
  logic [FW-1:0]   frac;

  always_comb begin
    sgn   = int_i[W-1];
    mag   = sgn ? (~int_i + 1'b1) : int_i;
    lz    = '0;
    found = 1'b0;
    for (int k = W - 1; k >= 0; k--) begin
      if (!found && mag[k]) begin
        lz    = LZ_W'(W - 1 - k);
        found = 1'b1;
      end
    end
    norm  = mag << lz;
    g_bit = norm[DROP-1];
    s_bit = |norm[DROP-2:0];
    unique case (rm_i)
      RM_NEAR_EVEN: inc = g_bit & (s_bit | norm[DROP]);
      RM_DOWN:      inc = (g_bit | s_bit) & sgn;
      RM_UP:        inc = (g_bit | s_bit) & ~sgn;
      default:      inc = 1'b0;
    endcase
    sum  = {1'b0, norm[W-1:DROP]} + (SIG_W+1)'(inc);
    ex   = EW'(BIAS + W - 1 - int'(lz) + int'(sum[SIG_W]));
    frac = sum[SIG_W] ? sum[FW:1] : sum[FW-1:0];
    if (!found) begin
      fp_o      = '0;
      inexact_o = 1'b0;
    end else begin
      fp_o      = {sgn, ex, frac};
      inexact_o = g_bit | s_bit;
    end
  end
endmodule

// File: rtl/i2d_mode_sel.sv
module i2d_mode_sel
  import i2d_pkg::*;
(
  input  logic       mem_form_i,
  input  logic       bcst_rc_i,
  input  logic [1:0] vlen_i,
  input  logic [1:0] rc_emb_i,
  input  logic [1:0] rc_glb_i,
  output rmode_e     rm_o,
  output logic       bcst_o
);
  logic use_emb;
  always_comb begin
    use_emb = !mem_form_i && bcst_rc_i && vlen_i[1];
    rm_o    = rmode_e'(use_emb ? rc_emb_i : rc_glb_i);
    bcst_o  = mem_form_i && bcst_rc_i;
  end
endmodule

// File: rtl/masked_i2d_cvt.sv
module masked_i2d_cvt
  import i2d_pkg::*;
#(
  parameter int unsigned NLANE = MAX_LN,
  parameter int unsigned LW    = LANE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [NLANE*LW-1:0] src_i,
  input  logic [NLANE*LW-1:0] dst_prev_i,
  input  logic [NLANE-1:0]    mask_i,
  input  logic                nomask_i,
  input  logic                zero_i,
  input  logic [1:0]          vlen_i,
  input  logic                mem_form_i,
  input  logic                bcst_rc_i,
  input  logic [1:0]          rc_emb_i,
  input  logic [1:0]          rc_glb_i,
  input  logic [3:0]          rsvd_i,
  output logic                valid_o,
  output logic [NLANE*LW-1:0] res_o,
  output logic                inexact_o,
  output logic                bad_enc_o
);
  localparam int unsigned VW = NLANE * LW;

  rmode_e           rm;
  logic             bcst, bad;
  logic [1:0]       vl_eff;
  logic [VW-1:0]    lane_res;
  logic [NLANE-1:0] lane_inx;

  i2d_mode_sel u_mode (
    .mem_form_i (mem_form_i),
    .bcst_rc_i  (bcst_rc_i),
    .vlen_i     (vlen_i),
    .rc_emb_i   (rc_emb_i),
    .rc_glb_i   (rc_glb_i),
    .rm_o       (rm),
    .bcst_o     (bcst)
  );

  assign vl_eff = vlen_i[1] ? 2'd2 : vlen_i;
  assign bad    = (rsvd_i != 4'hF);

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    logic [LW-1:0] op, fp;
    logic          inx, on, act;
    assign op  = bcst ? src_i[LW-1:0] : src_i[j*LW +: LW];
    assign on  = (j < (2 << vl_eff));
    assign act = nomask_i | mask_i[j];

    i2d_lane #(.W(LW)) u_cvt (
      .int_i     (op),
      .rm_i      (rm),
      .fp_o      (fp),
      .inexact_o (inx)
    );

    always_comb begin
      if (!on)          lane_res[j*LW +: LW] = '0;
      else if (act)     lane_res[j*LW +: LW] = fp;
      else if (zero_i)  lane_res[j*LW +: LW] = '0;
      else              lane_res[j*LW +: LW] = dst_prev_i[j*LW +: LW];
      lane_inx[j] = on & act & inx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      res_o     <= '0;
      inexact_o <= 1'b0;
      bad_enc_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o     <= bad ? dst_prev_i : lane_res;
        inexact_o <= !bad && (|lane_inx);
        bad_enc_o <= bad;
      end
    end
  end
endmodule

// File: rtl/i2d_cvt_chk.sv
module i2d_cvt_chk #(
  parameter int unsigned VW = 512,
  parameter int unsigned NL = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [VW-1:0] dst_prev_i,
  input logic [NL-1:0] mask_i,
  input logic          nomask_i,
  input logic          zero_i,
  input logic [1:0]    vlen_i,
  input logic [3:0]    rsvd_i,
  input logic          valid_o,
  input logic [VW-1:0] res_o,
  input logic          inexact_o,
  input logic          bad_enc_o
);
  logic ok_op, none_act;
  assign ok_op    = valid_i && rsvd_i == 4'hF;
  assign none_act = !nomask_i && mask_i == '0;

  AST_BAD_ENC_PASSES_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rsvd_i != 4'hF |=> bad_enc_o && !inexact_o && res_o == $past(dst_prev_i)); // R10
  AST_GOOD_ENC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_op |=> !bad_enc_o); // R10
  AST_UPPER_ZERO_128: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_op && vlen_i == 2'b00 |=> res_o[VW-1:128] == '0); // R5
  AST_UPPER_ZERO_256: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_op && vlen_i == 2'b01 |=> res_o[VW-1:256] == '0); // R5
  AST_MERGE_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_op && none_act && !zero_i && vlen_i[1] |=> res_o == $past(dst_prev_i)); // R3
  AST_ZERO_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_op && none_act && zero_i |=> res_o == '0); // R4
  AST_NO_INEXACT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_op && none_act |=> !inexact_o); // R11
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R12
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o) && $stable(inexact_o) && $stable(bad_enc_o)); // R12
endmodule

bind masked_i2d_cvt i2d_cvt_chk #(.VW(NLANE*LW), .NL(NLANE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .dst_prev_i (dst_prev_i),
  .mask_i     (mask_i),
  .nomask_i   (nomask_i),
  .zero_i     (zero_i),
  .vlen_i     (vlen_i),
  .rsvd_i     (rsvd_i),
  .valid_o    (valid_o),
  .res_o      (res_o),
  .inexact_o  (inexact_o),
  .bad_enc_o  (bad_enc_o)
);

// File: tb/tb_masked_i2d_cvt.sv
module tb_masked_i2d_cvt;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 0, rst_ni = 0, valid_i = 0;
  logic [511:0] src_i = '0, dst_prev_i = '0;
  logic [7:0]   mask_i = '0;
  logic         nomask_i = 0, zero_i = 0, mem_form_i = 0, bcst_rc_i = 0;
  logic [1:0]   vlen_i = 2'b10, rc_emb_i = 0, rc_glb_i = 0;
  logic [3:0]   rsvd_i = 4'hF;
  logic         valid_o, inexact_o, bad_enc_o;
  logic [511:0] res_o;

  int checks = 0, fails = 0;

  masked_i2d_cvt dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic signed [127:0] dbl_val(input logic [63:0] b);
    logic [11:0] e = {1'b0, b[62:52]};
    logic signed [127:0] m = {75'b0, 1'b1, b[51:0]};
    logic signed [127:0] v;
    if (b[62:0] == '0) return 0;
    if (e >= 1075) v = m <<< (e - 1075);
    else           v = m >>> (1075 - e);
    return b[63] ? -v : v;
  endfunction

  // reference: host nearest-even conversion, then step one ulp for directed modes
  function automatic logic [64:0] ref_cvt(input logic [63:0] x, input logic [1:0] rm);
    real r = real'($signed(x));
    logic [63:0] b = $realtobits(r);
    logic signed [127:0] xv = {{64{x[63]}}, x};
    logic signed [127:0] dv = dbl_val(b);
    logic gt;
    if (dv == xv) return {1'b0, b};
    gt = dv > xv;
    case (rm)
      2'b01: if (gt)  b = b[63] ? b + 1 : b - 1;
      2'b10: if (!gt) b = b[63] ? b - 1 : b + 1;
      2'b11: if (gt != b[63]) b = b - 1;
      default: ;
    endcase
    return {1'b1, b};
  endfunction

  task automatic expect_out(output logic [511:0] er, output logic ei, output logic eb);
    logic [1:0] rm;
    int nl;
    er = '0; ei = 0; eb = (rsvd_i != 4'hF);
    if (eb) begin er = dst_prev_i; return; end
    rm = (!mem_form_i && bcst_rc_i && vlen_i[1]) ? rc_emb_i : rc_glb_i;
    nl = vlen_i == 2'b00 ? 2 : vlen_i == 2'b01 ? 4 : 8;
    for (int j = 0; j < nl; j++) begin
      logic [63:0] op = (mem_form_i && bcst_rc_i) ? src_i[63:0] : src_i[j*64 +: 64];
      logic [64:0] c = ref_cvt(op, rm);
      if (nomask_i || mask_i[j]) begin
        er[j*64 +: 64] = c[63:0];
        ei |= c[64];
      end else if (!zero_i) er[j*64 +: 64] = dst_prev_i[j*64 +: 64];
    end
  endtask

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      for (int j = 0; j < 8; j++)
        if (act[j*64 +: 64] !== exp_v[j*64 +: 64])
          $display("FAIL %s lane %0d actual=%h expected=%h", req, j, act[j*64 +: 64], exp_v[j*64 +: 64]);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp_v);
    end
  endtask

  // one strobe, compare after the capturing edge
  task automatic run_op(input string req);
    logic [511:0] er; logic ei, eb;
    expect_out(er, ei, eb);
    valid_i = 1;
    @(posedge clk_i); @(negedge clk_i);
    valid_i = 0;
    chk1({req, " valid"}, valid_o, 1'b1);
    chk({req, " result"}, res_o, er);
    chk1({req, " inexact"}, inexact_o, ei);
    chk1({req, " bad_enc"}, bad_enc_o, eb);
  endtask

  task automatic defaults();
    mask_i = '0; nomask_i = 1; zero_i = 0; vlen_i = 2'b10; mem_form_i = 0;
    bcst_rc_i = 0; rc_emb_i = 0; rc_glb_i = 0; rsvd_i = 4'hF;
    for (int j = 0; j < 8; j++) dst_prev_i[j*64 +: 64] = {$urandom, $urandom};
  endtask

  task automatic rand_src();
    for (int j = 0; j < 8; j++) src_i[j*64 +: 64] = {$urandom, $urandom} >> ($urandom % 40);
  endtask

  task automatic t_reset();
    chk1("R12 reset valid", valid_o, 1'b0);
    chk("R12 reset result", res_o, '0);
    chk1("R12 reset inexact", inexact_o, 1'b0);
    chk1("R12 reset bad_enc", bad_enc_o, 1'b0);
  endtask

  task automatic t_exact();
    defaults();
    src_i = {64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
             64'h7FFF_FFFF_FFFF_FFFF, 64'h0020_0000_0000_0001, 64'h0020_0000_0000_0003,
             64'hFFDF_FFFF_FFFF_FFFF};
    run_op("R2 directed");
    chk("R2 zero is +0", {448'b0, res_o[511:448]}, 512'h0);
    chk("R2 min int", {448'b0, res_o[319:256]}, {448'b0, 64'hC3E0_0000_0000_0000});
  endtask

  task automatic t_round();
    for (int m = 0; m < 4; m++) begin
      for (int it = 0; it < 12; it++) begin
        defaults(); rand_src(); rc_glb_i = m[1:0];
        run_op(m == 0 ? "R6 R7 near-even" : m == 1 ? "R6 R7 down" : m == 2 ? "R6 R7 up" : "R6 R7 zero");
      end
      defaults(); rc_glb_i = m[1:0];
      for (int j = 0; j < 8; j++) src_i[j*64 +: 64] = (j[0] ? -64'sd1 : 64'sd1) * (64'sd9007199254740993 + 2*j);
      run_op("R6 ties");
    end
  endtask

  task automatic t_merge();
    defaults(); rand_src(); nomask_i = 0; mask_i = 8'b1010_0110; zero_i = 0;
    run_op("R3 merge");
    mask_i = 8'h00; run_op("R3 merge all off");
  endtask

  task automatic t_zero();
    defaults(); rand_src(); nomask_i = 0; mask_i = 8'b0101_1001; zero_i = 1;
    run_op("R4 zeroing");
    nomask_i = 1; mask_i = 8'h00; run_op("R3 R4 nomask overrides");
  endtask

  task automatic t_vlen();
    for (int v = 0; v < 4; v++) begin
      defaults(); rand_src(); vlen_i = v[1:0]; nomask_i = 0; mask_i = 8'hB5;
      run_op("R1 R5 length");
    end
    defaults(); rand_src(); vlen_i = 2'b00; zero_i = 0; nomask_i = 0; mask_i = 8'h00;
    run_op("R5 merge below 128");
  endtask

  task automatic t_bcst();
    defaults(); rand_src(); mem_form_i = 1; bcst_rc_i = 1; rc_emb_i = 2'b10; rc_glb_i = 2'b01;
    nomask_i = 0; mask_i = 8'h7E;
    run_op("R8 broadcast");
    mem_form_i = 0; run_op("R9 register no broadcast");
    mem_form_i = 1; bcst_rc_i = 0; run_op("R8 memory no broadcast");
  endtask

  task automatic t_emb_rc();
    for (int m = 0; m < 4; m++) begin
      defaults(); rand_src(); bcst_rc_i = 1; rc_emb_i = m[1:0]; rc_glb_i = ~m[1:0];
      run_op("R9 embedded rc");
      vlen_i = 2'b01; run_op("R7 R9 256 uses global");
    end
  endtask

  task automatic t_bad();
    defaults(); rand_src(); rsvd_i = 4'hE;
    run_op("R10 bad reserved");
    rsvd_i = 4'h0; vlen_i = 2'b00; run_op("R10 bad reserved 128");
    rsvd_i = 4'hF; run_op("R10 good reserved");
  endtask

  task automatic t_inexact_mask();
    defaults(); nomask_i = 0;
    for (int j = 0; j < 8; j++) src_i[j*64 +: 64] = 64'h0123_4567_89AB_CDEF;
    src_i[127:64] = 64'd5;
    mask_i = 8'b0000_0010;
    run_op("R11 rounded lanes masked off");
    chk1("R11 flag low", inexact_o, 1'b0);
    vlen_i = 2'b00; mask_i = 8'hFC;
    run_op("R11 lanes beyond length");
  endtask

  task automatic t_hold();
    logic [511:0] keep; logic ki, kb;
    defaults(); rand_src(); run_op("R12 strobe");
    keep = res_o; ki = inexact_o; kb = bad_enc_o;
    for (int c = 0; c < 4; c++) begin
      rand_src(); rsvd_i = 4'h3; rc_glb_i = c[1:0];
      @(posedge clk_i); @(negedge clk_i);
    end
    chk1("R12 idle valid", valid_o, 1'b0);
    chk("R12 idle hold", res_o, keep);
    chk1("R12 idle inexact", inexact_o, ki);
    chk1("R12 idle bad_enc", bad_enc_o, kb);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_exact();
    t_round();
    t_merge();
    t_zero();
    t_vlen();
    t_bcst();
    t_emb_rc();
    t_bad();
    t_inexact_mask();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule